// File: doc/BRIEF.md
# Bounds Register Move Unit

This block holds a small file of bounds registers. Each register is a pair of 64-bit values: a lower limit and an upper limit. The block carries out one bounds-move operation per accepted request. A request arrives already decoded into a direction opcode byte, a destination index, a source index, a memory-form flag, a 64-bit-mode flag, a lock flag and a byte address. From these the block does one of three things: it copies one register into another, it loads a register from memory, or it stores a register to memory. It reaches memory through a single-beat request/response port that carries a byte address, write data, byte enables and read data, plus an error flag on the response.

The control is a sequencer with six named states. `S_IDLE` accepts a request. A register move or a faulted request goes from there straight to `S_REPORT`. A memory form goes to `S_LO_ISSUE`, then `S_LO_WAIT`, which waits for the lower-word response. After that comes `S_HI_ISSUE`, then `S_HI_WAIT`, which waits for the upper-word response. An error response in either wait state branches at once to `S_REPORT`. `S_REPORT` raises the completion pulse for one cycle and returns to `S_IDLE`.

In 64-bit mode the memory image is two 64-bit words, at the base address and at base+8. In the other mode it is two 32-bit words, at base and at base+4, and each word is zero-extended when it is loaded. The block never updates any status flags.

Top module: `bound_xfer_unit`

## Requirements
- R1: After reset every bounds register reads as zero, `req_ready` is 1, and both `cpl_valid` and `mem_req_valid` are 0.
- R2: A register move has `req_mem`=0 and opcode 8'h1A or 8'h1B. It copies both halves of register `req_src` into register `req_dst`. It reports `cpl_status`=2'b00 (done) in the cycle after acceptance and makes no memory transaction.
- R3: A 64-bit load (opcode 8'h1A, `req_mem`=1, `req_wide`=1) issues a read at `req_addr` and then a read at `req_addr`+8, both with byte enables 8'hFF. The first word becomes the lower limit and the second the upper limit.
- R4: A load with `req_wide`=0 issues a read at `req_addr` and then a read at `req_addr`+4, both with byte enables 8'h0F. Bits 31:0 of each response are zero-extended to 64 bits. The first becomes the lower limit and the second the upper limit.
- R5: A 64-bit store (opcode 8'h1B, `req_mem`=1, `req_wide`=1) writes the lower limit at `req_addr` and the upper limit at `req_addr`+8, both with byte enables 8'hFF. Byte lane i carries bits 8i+7:8i and targets address+i.
- R6: A store with `req_wide`=0 writes bits 31:0 of the lower limit at `req_addr` and bits 31:0 of the upper limit at `req_addr`+4, both with byte enables 8'h0F. Exactly 8 bytes change.
- R7: An opcode other than 8'h1A or 8'h1B completes with `cpl_status`=2'b01 (invalid opcode). It makes no memory transaction and changes no register.
- R8: An index of 4 or more on an operand that names a register completes with status 2'b01 and changes no state. For opcode 8'h1A the destination always names a register. For opcode 8'h1B the source always names a register. The remaining operand names a register only when `req_mem`=0, and is ignored when `req_mem`=1.
- R9: `req_lock`=1 with a register destination completes with status 2'b01 and changes nothing. `req_lock`=1 on a store to memory is legal.
- R10: A load writes its destination only after both reads succeed. An error response on either read completes with status 2'b10 (memory error), leaves the register unchanged, and issues no further memory request.
- R11: Every accepted request produces exactly one one-cycle `cpl_valid` pulse. `req_ready` stays 0 from acceptance until the cycle after that pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; accepted when `req_ready` is 1 |
| req_ready | output | 1 | Unit idle and able to accept |
| req_opcode | input | 8 | Direction byte: 8'h1A load direction, 8'h1B store direction |
| req_dst | input | IDX_W | Destination register index |
| req_src | input | IDX_W | Source register index |
| req_mem | input | 1 | 1 = memory form, 0 = register form |
| req_wide | input | 1 | 1 = 64-bit memory image, 0 = 32-bit image |
| req_lock | input | 1 | Lock flag present on the instruction |
| req_addr | input | AW | Base byte address of the memory operand |
| mem_req_valid | output | 1 | Single-cycle memory request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | AW | Byte address of the word |
| mem_req_wdata | output | 64 | Write data, lane i at address+i |
| mem_req_be | output | 8 | Byte enables, bit i for address+i |
| mem_rsp_valid | input | 1 | Memory response for the outstanding request |
| mem_rsp_err | input | 1 | Response carries an error |
| mem_rsp_rdata | input | 64 | Read data, lane i from address+i |
| cpl_valid | output | 1 | One-cycle completion pulse |
| cpl_status | output | 2 | 00 done, 01 invalid opcode, 10 memory error |

## Verification
The bench builds the unit with the defaults: four registers, a 4-bit index field and 32-bit addresses. The 4-bit index allows values from 4 to 15, so the out-of-range fault paths can be driven on both the destination and the source operand. The memory model uses a settable response delay and can inject an error on a chosen transaction. This makes the long wait states reachable, along with the abort after either the lower or the upper word.

// File: rtl/bxu_pkg.sv
package bxu_pkg;

    localparam int LIM_W = 64;

    typedef struct packed {
        logic [LIM_W-1:0] ub;
        logic [LIM_W-1:0] lb;
    } lim_pair_t;

    typedef enum logic [1:0] {
        OPK_MOVE  = 2'd0,
        OPK_LOAD  = 2'd1,
        OPK_STORE = 2'd2
    } op_kind_e;

    typedef enum logic [1:0] {
        CPL_OK     = 2'b00,
        CPL_UD     = 2'b01,
        CPL_MEMERR = 2'b10
    } cpl_e;

    localparam logic [7:0] OPC_TO_REG = 8'h1A;
    localparam logic [7:0] OPC_TO_RM  = 8'h1B;

endpackage

// File: rtl/bxu_decode.sv
module bxu_decode
    import bxu_pkg::*;
#(
    parameter int NREG  = 4,
    parameter int IDX_W = 4
) (
    input  logic [7:0]       opcode,
    input  logic [IDX_W-1:0] dst,
    input  logic [IDX_W-1:0] src,
    input  logic             mem,
    input  logic             lock,
    output logic             fault,
    output op_kind_e         kind
);

    localparam logic [IDX_W:0] NREG_W = (IDX_W+1)'(NREG);

    logic dir_ld, dir_st;
    logic dst_names_reg, src_names_reg;
    logic bad_opc, bad_idx, bad_lock;

    always_comb begin
        dir_ld        = (opcode == OPC_TO_REG);
        dir_st        = (opcode == OPC_TO_RM);
        dst_names_reg = dir_ld || !mem;
        src_names_reg = dir_st || !mem;
        bad_opc       = !(dir_ld || dir_st);
        bad_idx       = (dst_names_reg && ({1'b0, dst} >= NREG_W)) ||
                        (src_names_reg && ({1'b0, src} >= NREG_W));
        bad_lock      = lock && dst_names_reg;
        fault         = bad_opc || bad_idx || bad_lock;
        if (!mem)
            kind = OPK_MOVE;
        else if (dir_ld)
            kind = OPK_LOAD;
        else
            kind = OPK_STORE;
    end

endmodule

// File: rtl/bxu_regfile.sv
module bxu_regfile
    import bxu_pkg::*;
#(
    parameter int NREG  = 4,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  lim_pair_t        wdata,
    input  logic [IDX_W-1:0] raddr,
    output lim_pair_t        rdata
);

    lim_pair_t        ent [NREG];
    logic [NREG-1:0]  hit;

    for (genvar g = 0; g < NREG; g++) begin : g_hit
        assign hit[g] = we && (waddr == IDX_W'(g));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) ent[i] <= '0;
        end else begin
            for (int i = 0; i < NREG; i++)
                if (hit[i]) ent[i] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NREG; i++)
            if (raddr == IDX_W'(i)) rdata = ent[i];
    end

    // R8: a write never targets an index outside the file
    a_r8_waddr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> ({1'b0, waddr} < (IDX_W+1)'(NREG)));

endmodule

// File: rtl/bxu_seq.sv
module bxu_seq
    import bxu_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int AW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             dec_fault,
    input  op_kind_e         dec_kind,
    input  logic             req_wide,
    input  logic [IDX_W-1:0] req_dst,
    input  logic [AW-1:0]    req_addr,
    input  lim_pair_t        src_pair,
    output logic             rf_we,
    output logic [IDX_W-1:0] rf_waddr,
    output lim_pair_t        rf_wdata,
    output logic             mem_req_valid,
    output logic             mem_req_write,
    output logic [AW-1:0]    mem_req_addr,
    output logic [LIM_W-1:0] mem_req_wdata,
    output logic [7:0]       mem_req_be,
    input  logic             mem_rsp_valid,
    input  logic             mem_rsp_err,
    input  logic [LIM_W-1:0] mem_rsp_rdata,
    output logic             cpl_valid,
    output cpl_e             cpl_status
);

    localparam int HALF_W = LIM_W / 2;
    localparam logic [AW-1:0] STEP_WIDE   = AW'(8);
    localparam logic [AW-1:0] STEP_NARROW = AW'(4);

    typedef enum logic [2:0] {
        S_IDLE,
        S_LO_ISSUE,
        S_LO_WAIT,
        S_HI_ISSUE,
        S_HI_WAIT,
        S_REPORT
    } state_e;

    state_e           state, state_nx;
    logic             accept;
    logic             store_q, wide_q;
    logic [IDX_W-1:0] dst_q;
    logic [AW-1:0]    base_q;
    logic [LIM_W-1:0] lo_buf;
    lim_pair_t        st_buf;
    cpl_e             status_q;
    logic [LIM_W-1:0] rsp_word;
    logic [LIM_W-1:0] st_pick;
    logic             hi_phase;
    logic             move_wr, load_wr;

    assign accept = req_valid && (state == S_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (req_valid) begin
                    if (dec_fault || dec_kind == OPK_MOVE) state_nx = S_REPORT;
                    else                                   state_nx = S_LO_ISSUE;
                end
            end
            S_LO_ISSUE: state_nx = S_LO_WAIT;
            S_LO_WAIT: begin
                if (mem_rsp_valid) state_nx = mem_rsp_err ? S_REPORT : S_HI_ISSUE;
            end
            S_HI_ISSUE: state_nx = S_HI_WAIT;
            S_HI_WAIT: begin
                if (mem_rsp_valid) state_nx = S_REPORT;
            end
            S_REPORT: state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    // operation context and lower-word buffer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            store_q  <= 1'b0;
            wide_q   <= 1'b0;
            dst_q    <= '0;
            base_q   <= '0;
            lo_buf   <= '0;
            st_buf   <= '0;
            status_q <= CPL_OK;
        end else begin
            if (accept) begin
                status_q <= dec_fault ? CPL_UD : CPL_OK;
                store_q  <= (dec_kind == OPK_STORE);
                wide_q   <= req_wide;
                dst_q    <= req_dst;
                base_q   <= req_addr;
                st_buf   <= src_pair;
            end
            if (state == S_LO_WAIT && mem_rsp_valid) begin
                lo_buf <= rsp_word;
                if (mem_rsp_err) status_q <= CPL_MEMERR;
            end
            if (state == S_HI_WAIT && mem_rsp_valid && mem_rsp_err)
                status_q <= CPL_MEMERR;
        end
    end

    // outputs
    always_comb begin
        hi_phase      = (state == S_HI_ISSUE);
        rsp_word      = wide_q ? mem_rsp_rdata
                               : {{HALF_W{1'b0}}, mem_rsp_rdata[HALF_W-1:0]};
        st_pick       = hi_phase ? st_buf.ub : st_buf.lb;

        req_ready     = (state == S_IDLE);
        cpl_valid     = (state == S_REPORT);
        cpl_status    = status_q;

        mem_req_valid = (state == S_LO_ISSUE) || hi_phase;
        mem_req_write = store_q;
        mem_req_addr  = base_q + (hi_phase ? (wide_q ? STEP_WIDE : STEP_NARROW) : '0);
        mem_req_be    = wide_q ? 8'hFF : 8'h0F;
        if (!store_q)
            mem_req_wdata = '0;
        else if (wide_q)
            mem_req_wdata = st_pick;
        else
            mem_req_wdata = {{HALF_W{1'b0}}, st_pick[HALF_W-1:0]};

        move_wr  = accept && !dec_fault && (dec_kind == OPK_MOVE);
        load_wr  = (state == S_HI_WAIT) && mem_rsp_valid && !mem_rsp_err && !store_q;
        rf_we    = move_wr || load_wr;
        rf_waddr = move_wr ? req_dst : dst_q;
        rf_wdata = move_wr ? src_pair : '{ub: rsp_word, lb: lo_buf};
    end

    // R11: completion is a single-cycle pulse
    a_r11_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |=> !cpl_valid);

    // R11: unit is ready again right after completion
    a_r11_ready_after: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |=> req_ready);

    // R11: unit is busy in the cycle after acceptance
    a_r11_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R3: memory requests are single-beat
    a_r3_single_beat: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);

    // R10: an error response ends the operation with a memory-error status
    a_r10_err_reports: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rsp_valid && mem_rsp_err && (state == S_LO_WAIT || state == S_HI_WAIT))
        |=> (cpl_valid && cpl_status == CPL_MEMERR));

    // R10: no register write on an error response
    a_r10_no_write_on_err: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rsp_valid && mem_rsp_err) |-> !rf_we);

endmodule

// File: rtl/bound_xfer_unit.sv
module bound_xfer_unit
    import bxu_pkg::*;
#(
    parameter int NREG  = 4,
    parameter int IDX_W = 4,
    parameter int AW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [7:0]       req_opcode,
    input  logic [IDX_W-1:0] req_dst,
    input  logic [IDX_W-1:0] req_src,
    input  logic             req_mem,
    input  logic             req_wide,
    input  logic             req_lock,
    input  logic [AW-1:0]    req_addr,
    output logic             mem_req_valid,
    output logic             mem_req_write,
    output logic [AW-1:0]    mem_req_addr,
    output logic [63:0]      mem_req_wdata,
    output logic [7:0]       mem_req_be,
    input  logic             mem_rsp_valid,
    input  logic             mem_rsp_err,
    input  logic [63:0]      mem_rsp_rdata,
    output logic             cpl_valid,
    output logic [1:0]       cpl_status
);

    localparam logic [IDX_W:0] NREG_W = (IDX_W+1)'(NREG);

    logic             dec_fault;
    op_kind_e         dec_kind;
    lim_pair_t        src_pair;
    logic             rf_we;
    logic [IDX_W-1:0] rf_waddr;
    lim_pair_t        rf_wdata;
    cpl_e             seq_status;

    bxu_decode #(.NREG(NREG), .IDX_W(IDX_W)) u_dec (
        .opcode (req_opcode),
        .dst    (req_dst),
        .src    (req_src),
        .mem    (req_mem),
        .lock   (req_lock),
        .fault  (dec_fault),
        .kind   (dec_kind)
    );

    bxu_regfile #(.NREG(NREG), .IDX_W(IDX_W)) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (rf_we),
        .waddr  (rf_waddr),
        .wdata  (rf_wdata),
        .raddr  (req_src),
        .rdata  (src_pair)
    );

    bxu_seq #(.IDX_W(IDX_W), .AW(AW)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .dec_fault     (dec_fault),
        .dec_kind      (dec_kind),
        .req_wide      (req_wide),
        .req_dst       (req_dst),
        .req_addr      (req_addr),
        .src_pair      (src_pair),
        .rf_we         (rf_we),
        .rf_waddr      (rf_waddr),
        .rf_wdata      (rf_wdata),
        .mem_req_valid (mem_req_valid),
        .mem_req_write (mem_req_write),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .mem_req_be    (mem_req_be),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_err   (mem_rsp_err),
        .mem_rsp_rdata (mem_rsp_rdata),
        .cpl_valid     (cpl_valid),
        .cpl_status    (seq_status)
    );

    assign cpl_status = seq_status;

    // R7: unknown opcode is reported as invalid in the next cycle
    a_r7_bad_opcode: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_opcode != 8'h1A && req_opcode != 8'h1B)
        |=> (cpl_valid && cpl_status == 2'b01));

    // R9: lock on a load-direction request always faults
    a_r9_lock_reg_dst: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_opcode == 8'h1A && req_lock)
        |=> (cpl_valid && cpl_status == 2'b01));

    // R2: legal register move completes with done status in the next cycle
    a_r2_move_done: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_mem && !req_lock &&
         (req_opcode == 8'h1A || req_opcode == 8'h1B) &&
         ({1'b0, req_dst} < NREG_W) && ({1'b0, req_src} < NREG_W))
        |=> (cpl_valid && cpl_status == 2'b00));

    // R7: a faulted request never reaches memory
    a_r7_fault_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && cpl_status == 2'b01) |-> !mem_req_valid);

endmodule

// File: tb/tb_bound_xfer_unit.sv
module tb_bound_xfer_unit;

    localparam int IDX_W = 4;
    localparam int AW    = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [7:0]       req_opcode = '0;
    logic [IDX_W-1:0] req_dst = '0;
    logic [IDX_W-1:0] req_src = '0;
    logic             req_mem = 1'b0;
    logic             req_wide = 1'b0;
    logic             req_lock = 1'b0;
    logic [AW-1:0]    req_addr = '0;
    logic             mem_req_valid, mem_req_write;
    logic [AW-1:0]    mem_req_addr;
    logic [63:0]      mem_req_wdata;
    logic [7:0]       mem_req_be;
    logic             mem_rsp_valid = 1'b0;
    logic             mem_rsp_err = 1'b0;
    logic [63:0]      mem_rsp_rdata = '0;
    logic             cpl_valid;
    logic [1:0]       cpl_status;

    bound_xfer_unit #(.NREG(4), .IDX_W(IDX_W), .AW(AW)) dut (.*);

    always #2.5 clk = ~clk;

    int nchk = 0, nfail = 0, ncpl = 0;
    bit finished = 0;

    // memory model
    logic [7:0]  mem [256];
    logic [31:0] log_addr [16];
    logic        log_wr   [16];
    logic [7:0]  log_be   [16];
    int ntx = 0, rsp_lat = 0, err_at = -1;
    bit pend = 0;
    int pcnt = 0, pid = 0;
    logic [63:0] prd;

    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        mem_rsp_err   = 1'b0;
        if (cpl_valid) ncpl++;
        if (pend) begin
            if (pcnt == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_err   = (pid == err_at);
                mem_rsp_rdata = prd;
                pend = 0;
            end else pcnt--;
        end
        if (mem_req_valid) begin
            if (ntx < 16) begin
                log_addr[ntx] = mem_req_addr;
                log_wr[ntx]   = mem_req_write;
                log_be[ntx]   = mem_req_be;
            end
            for (int i = 0; i < 8; i++) begin
                prd[8*i +: 8] = mem[8'(mem_req_addr + 32'(i))];
                if (mem_req_write && mem_req_be[i] && ntx != err_at)
                    mem[8'(mem_req_addr + 32'(i))] = mem_req_wdata[8*i +: 8];
            end
            pend = 1; pcnt = rsp_lat; pid = ntx; ntx++;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put64(input int a, input logic [63:0] v);
        for (int i = 0; i < 8; i++) mem[8'(a + i)] = v[8*i +: 8];
    endtask

    function automatic logic [63:0] get64(input int a);
        logic [63:0] v;
        for (int i = 0; i < 8; i++) v[8*i +: 8] = mem[8'(a + i)];
        return v;
    endfunction

    bit ready_leak;

    task automatic do_req(input logic [7:0] opc, input int d, input int s,
                          input logic m, input logic w, input logic lk,
                          input int a, output logic [1:0] st, output int lat);
        @(negedge clk);
        ntx = 0; ready_leak = 0;
        req_opcode = opc; req_dst = IDX_W'(d); req_src = IDX_W'(s);
        req_mem = m; req_wide = w; req_lock = lk; req_addr = AW'(a);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!cpl_valid && lat < 60) begin
            if (req_ready) ready_leak = 1;
            @(negedge clk);
            lat++;
        end
        st = cpl_status;
    endtask

    task automatic peek(input int idx, output logic [63:0] lb, output logic [63:0] ub);
        logic [1:0] st; int lat;
        do_req(8'h1B, 0, idx, 1'b1, 1'b1, 1'b0, 'hC0, st, lat);
        lb = get64('hC0); ub = get64('hC8);
    endtask

    localparam logic [63:0] W_LO = 64'h1122_3344_5566_7788;
    localparam logic [63:0] W_HI = 64'h99AA_BBCC_DDEE_F001;

    task automatic t_reset;
        logic [63:0] lb, ub;
        chk("R1 req_ready", 64'(req_ready), 64'd1);
        chk("R1 cpl_valid", 64'(cpl_valid), 64'd0);
        chk("R1 mem_req_valid", 64'(mem_req_valid), 64'd0);
        for (int r = 0; r < 4; r++) begin
            peek(r, lb, ub);
            chk("R1 reg lb zero", lb, 64'd0);
            chk("R1 reg ub zero", ub, 64'd0);
        end
    endtask

    task automatic t_load_wide;
        logic [1:0] st; int lat; logic [63:0] lb, ub;
        put64('h10, W_LO); put64('h18, W_HI);
        rsp_lat = 3;
        do_req(8'h1A, 1, 0, 1'b1, 1'b1, 1'b0, 'h10, st, lat);
        rsp_lat = 0;
        chk("R3 status", 64'(st), 64'd0);
        chk("R3 txn count", 64'(ntx), 64'd2);
        chk("R3 lo addr", 64'(log_addr[0]), 64'h10);
        chk("R3 hi addr", 64'(log_addr[1]), 64'h18);
        chk("R3 be", 64'({log_be[0], log_be[1]}), 64'hFFFF);
        chk("R3 read dir", 64'({log_wr[0], log_wr[1]}), 64'd0);
        chk("R11 busy while waiting", 64'(ready_leak), 64'd0);
        peek(1, lb, ub);
        chk("R3 lb", lb, W_LO);
        chk("R3 ub", ub, W_HI);
    endtask

    task automatic t_load_narrow;
        logic [1:0] st; int lat; logic [63:0] lb, ub;
        put64('h40, 64'hDEAD_BEEF_0BAD_F00D); put64('h48, 64'hFFFF_FFFF_FFFF_FFFF);
        do_req(8'h1A, 2, 0, 1'b1, 1'b0, 1'b0, 'h40, st, lat);
        chk("R4 status", 64'(st), 64'd0);
        chk("R4 lo addr", 64'(log_addr[0]), 64'h40);
        chk("R4 hi addr", 64'(log_addr[1]), 64'h44);
        chk("R4 be", 64'({log_be[0], log_be[1]}), 64'h0F0F);
        peek(2, lb, ub);
        chk("R4 lb zero-ext", lb, 64'h0000_0000_0BAD_F00D);
        chk("R4 ub zero-ext", ub, 64'h0000_0000_DEAD_BEEF);
    endtask

    task automatic t_move;
        logic [1:0] st; int lat; logic [63:0] lb, ub;
        do_req(8'h1A, 3, 1, 1'b0, 1'b1, 1'b0, 0, st, lat);
        chk("R2 status", 64'(st), 64'd0);
        chk("R2 latency", 64'(lat), 64'd1);
        chk("R2 no mem", 64'(ntx), 64'd0);
        peek(3, lb, ub);
        chk("R2 lb", lb, W_LO);
        chk("R2 ub", ub, W_HI);
        do_req(8'h1B, 0, 2, 1'b0, 1'b0, 1'b0, 0, st, lat);
        chk("R2 1B status", 64'(st), 64'd0);
        peek(0, lb, ub);
        chk("R2 1B lb", lb, 64'h0BAD_F00D);
        chk("R2 1B ub", ub, 64'hDEAD_BEEF);
    endtask

    task automatic t_store;
        logic [1:0] st; int lat;
        for (int i = 'h80; i < 'h90; i++) mem[i] = 8'hEE;
        do_req(8'h1B, 0, 1, 1'b1, 1'b0, 1'b0, 'h80, st, lat);
        chk("R6 status", 64'(st), 64'd0);
        chk("R6 addrs", 64'({log_addr[0], log_addr[1]}), {32'h80, 32'h84});
        chk("R6 be/write", 64'({log_be[0], log_be[1], 6'd0, log_wr[0], log_wr[1]}), 64'h0F0F03);
        chk("R6 data", get64('h80), {W_HI[31:0], W_LO[31:0]});
        chk("R6 untouched", get64('h88), 64'hEEEE_EEEE_EEEE_EEEE);
        do_req(8'h1B, 0, 1, 1'b1, 1'b1, 1'b0, 'hA0, st, lat);
        chk("R5 addrs", 64'({log_addr[0], log_addr[1]}), {32'hA0, 32'hA8});
        chk("R5 be", 64'({log_be[0], log_be[1]}), 64'hFFFF);
        chk("R5 lb", get64('hA0), W_LO);
        chk("R5 ub", get64('hA8), W_HI);
    endtask

    task automatic t_faults;
        logic [1:0] st; int lat; logic [63:0] lb, ub;
        do_req(8'h1C, 0, 1, 1'b0, 1'b1, 1'b0, 0, st, lat);
        chk("R7 status", 64'(st), 64'd1);
        chk("R7 no mem", 64'(ntx), 64'd0);
        peek(0, lb, ub);
        chk("R7 reg0 unchanged", lb, 64'h0BAD_F00D);
        do_req(8'h1A, 4, 0, 1'b1, 1'b1, 1'b0, 'h10, st, lat);
        chk("R8 dst index fault", 64'(st), 64'd1);
        chk("R8 no mem", 64'(ntx), 64'd0);
        do_req(8'h1A, 0, 5, 1'b0, 1'b1, 1'b0, 0, st, lat);
        chk("R8 src index fault", 64'(st), 64'd1);
        peek(0, lb, ub);
        chk("R8 reg0 unchanged", ub, 64'hDEAD_BEEF);
        do_req(8'h1B, 0, 7, 1'b1, 1'b1, 1'b0, 'hA0, st, lat);
        chk("R8 store src fault", 64'(st), 64'd1);
        do_req(8'h1B, 9, 1, 1'b1, 1'b1, 1'b0, 'hB0, st, lat);
        chk("R8 mem dst index ignored", 64'(st), 64'd0);
        do_req(8'h1A, 1, 0, 1'b1, 1'b1, 1'b1, 'h40, st, lat);
        chk("R9 lock load", 64'(st), 64'd1);
        do_req(8'h1B, 1, 0, 1'b0, 1'b1, 1'b1, 0, st, lat);
        chk("R9 lock move", 64'(st), 64'd1);
        peek(1, lb, ub);
        chk("R9 reg1 unchanged", lb, W_LO);
        do_req(8'h1B, 0, 0, 1'b1, 1'b1, 1'b1, 'hB0, st, lat);
        chk("R9 lock store legal", 64'(st), 64'd0);
    endtask

    task automatic t_mem_err;
        logic [1:0] st; int lat; logic [63:0] lb, ub;
        err_at = 0;
        do_req(8'h1A, 3, 0, 1'b1, 1'b1, 1'b0, 'h40, st, lat);
        chk("R10 lo err status", 64'(st), 64'd2);
        chk("R10 lo err single txn", 64'(ntx), 64'd1);
        err_at = 1;
        do_req(8'h1A, 3, 0, 1'b1, 1'b1, 1'b0, 'h40, st, lat);
        chk("R10 hi err status", 64'(st), 64'd2);
        chk("R10 hi err txns", 64'(ntx), 64'd2);
        err_at = -1;
        peek(3, lb, ub);
        chk("R10 reg3 lb unchanged", lb, W_LO);
        chk("R10 reg3 ub unchanged", ub, W_HI);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load_wide();
        t_load_narrow();
        t_move();
        t_store();
        t_faults();
        t_mem_err();
        repeat (3) @(negedge clk);
        // R11: one pulse per request (4 peeks + 2 + 2 + 2+... counted below)
        chk("R11 pulse count", 64'(ncpl), 64'(nreq_total()));
        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    // requests issued: reset 4 peeks; wide load 1+1; narrow 1+1; move 2+2;
    // store 2; faults 8 + 3 peeks; errors 2 + 1 peek
    function automatic int nreq_total();
        return 4 + 2 + 2 + 4 + 2 + 11 + 3;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nchk++; nfail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule